// File: doc/BRIEF.md
# Lab Board Session Sequencer

This block is the central controller of an adapter that sits between a host computer and a laboratory experiment board. Each session starts when the host link signals that it is ready. The sequencer then captures the board's real identity from local DIP-switch inputs and reads three bytes from the host. The first two bytes are the board type and serial number the host expects. The third byte is a draw value that selects the setting of a cyclic counter on the experiment board.

After the three bytes arrive, the sequencer requests a buzzer beep to show that a connection exists. It then compares the real identity with the requested one. When the two match, it starts an external draw controller and waits for that controller to finish. In every case it ends the session by writing a one-byte result code back to the host. It then waits for the next ready indication.

Each host byte transfer uses a request/acknowledge handshake. The sequencer holds the request high until the port unit acknowledges it, so the host side may stall for any number of cycles.

Top module: `session_seq`

## Requirements
- R1: While no session is running, `busy`, `rdReq`, `wrReq`, `buzzReq` and `drawStart` stay low. A session starts only when `hostReady` is seen high at a clock edge.
- R2: A session reads exactly three bytes, in this order: requested type, requested serial number, draw value. Each read holds `rdReq` high until a cycle in which `rdAck` is high, and `rdData` is captured in that cycle.
- R3: The real type and number are sampled from `dipType`/`dipNum` once, in the cycle after the session starts. Changes on those inputs later in the session have no effect on the result.
- R4: After the third byte is read, and before any draw start or result write, `buzzReq` is high for exactly one cycle per session.
- R5: If the real type differs from the requested type, the result code is 1. This holds even when the serial number also differs.
- R6: If the types match but the real serial number differs from the requested one, the result code is 2.
- R7: If both type and serial number match, the result code is 5.
- R8: `drawStart` pulses for one cycle only in sessions whose result is 5. While it is high, `drawValue` equals the low DRAW_W bits of the draw byte (DRAW_W = 2 by default). Sessions with result 1 or 2 never pulse `drawStart`.
- R9: In a session whose result is 5, `wrReq` does not rise until `drawDone` has been seen high.
- R10: The result code goes out on `wrData` with `wrReq` held high until `wrAck`, and `wrData` stays stable meanwhile. `busy` is high from the cycle after `hostReady` is seen until the write is acknowledged, and low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReady | input | 1 | Host link ready; starts a session |
| rdReq | output | 1 | Byte read request to port unit |
| rdAck | input | 1 | Read acknowledge; `rdData` valid |
| rdData | input | W | Byte read from the host |
| wrReq | output | 1 | Byte write request to port unit |
| wrAck | input | 1 | Write acknowledge |
| wrData | output | W | Result code byte |
| dipType | input | W | Real board type from switches |
| dipNum | input | W | Real board serial number from switches |
| buzzReq | output | 1 | One-cycle buzzer request |
| drawStart | output | 1 | One-cycle draw controller start |
| drawValue | output | DRAW_W | Draw target for the counter |
| drawDone | input | 1 | Draw controller has reached its target |
| busy | output | 1 | Session in progress |

## Verification
The hardest case to reach from the ports is the early-write hazard on success. For R9 to be tested, `drawDone` has to be held off for several cycles after `drawStart`, while the port unit would accept a write at once. The bench serves reads and writes on demand, delays `drawDone` by a set amount and watches `wrReq` in every cycle before it. A second hard case is R3. There the bench inverts the DIP inputs in the very cycle it acknowledges the first read, so a sequencer that compared live switch values would return the wrong code. Sessions with stalled acknowledges check that requests are held until they are accepted.

// File: rtl/session_seq_pkg.sv
package session_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_LATCH,
    S_RD_TYPE,
    S_RD_NUM,
    S_RD_DRAW,
    S_BUZZ,
    S_CMP,
    S_DRAW_GO,
    S_DRAW_WAIT,
    S_WR_RES
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchDip;
    logic capType;
    logic capNum;
    logic capDraw;
    logic evalCode;
  } dpCtrl_t;

  localparam int CODE_TYPE_ERR = 1;
  localparam int CODE_NUM_ERR  = 2;
  localparam int CODE_OK       = 5;

endpackage

// File: rtl/session_seq_dp.sv
module session_seq_dp
  import session_seq_pkg::*;
#(
  parameter int W      = 8,
  parameter int DRAW_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [W-1:0]      rdData,
  input  logic [W-1:0]      dipType,
  input  logic [W-1:0]      dipNum,
  output logic              typeMatch,
  output logic              numMatch,
  output logic [W-1:0]      resultCode,
  output logic [DRAW_W-1:0] drawValue
);

  logic [W-1:0]      actType, actNum, reqType, reqNum;
  logic [DRAW_W-1:0] drawReg;
  logic [W-1:0]      codeReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actType <= '0;
      actNum  <= '0;
      reqType <= '0;
      reqNum  <= '0;
      drawReg <= '0;
      codeReg <= '0;
    end else begin
      if (ctrl.latchDip) begin
        actType <= dipType;
        actNum  <= dipNum;
      end
      if (ctrl.capType) reqType <= rdData;
      if (ctrl.capNum)  reqNum  <= rdData;
      if (ctrl.capDraw) drawReg <= rdData[DRAW_W-1:0];
      if (ctrl.evalCode) begin
        if (actType != reqType)     codeReg <= W'(CODE_TYPE_ERR);
        else if (actNum != reqNum)  codeReg <= W'(CODE_NUM_ERR);
        else                        codeReg <= W'(CODE_OK);
      end
    end
  end

  assign typeMatch  = (actType == reqType);
  assign numMatch   = (actNum == reqNum);
  assign resultCode = codeReg;
  assign drawValue  = drawReg;

endmodule

// File: rtl/session_seq_ctrl.sv
module session_seq_ctrl
  import session_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    hostReady,
  input  logic    rdAck,
  input  logic    wrAck,
  input  logic    drawDone,
  input  logic    typeMatch,
  input  logic    numMatch,
  output dpCtrl_t ctrl,
  output logic    rdReq,
  output logic    wrReq,
  output logic    buzzReq,
  output logic    drawStart,
  output logic    busy
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:      if (hostReady) nextState = S_LATCH;
      S_LATCH:     nextState = S_RD_TYPE;
      S_RD_TYPE:   if (rdAck) nextState = S_RD_NUM;
      S_RD_NUM:    if (rdAck) nextState = S_RD_DRAW;
      S_RD_DRAW:   if (rdAck) nextState = S_BUZZ;
      S_BUZZ:      nextState = S_CMP;
      S_CMP:       nextState = (typeMatch && numMatch) ? S_DRAW_GO : S_WR_RES;
      S_DRAW_GO:   nextState = S_DRAW_WAIT;
      S_DRAW_WAIT: if (drawDone) nextState = S_WR_RES;
      S_WR_RES:    if (wrAck) nextState = S_IDLE;
      default:     nextState = S_IDLE;
    endcase
  end

  always_comb begin
    ctrl          = '0;
    ctrl.latchDip = (state == S_LATCH);
    ctrl.capType  = (state == S_RD_TYPE) && rdAck;
    ctrl.capNum   = (state == S_RD_NUM)  && rdAck;
    ctrl.capDraw  = (state == S_RD_DRAW) && rdAck;
    ctrl.evalCode = (state == S_CMP);
  end

  assign rdReq     = (state == S_RD_TYPE) || (state == S_RD_NUM) || (state == S_RD_DRAW);
  assign wrReq     = (state == S_WR_RES);
  assign buzzReq   = (state == S_BUZZ);
  assign drawStart = (state == S_DRAW_GO);
  assign busy      = (state != S_IDLE);

endmodule

// File: rtl/session_seq.sv
module session_seq
  import session_seq_pkg::*;
#(
  parameter int W      = 8,
  parameter int DRAW_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReady,
  output logic              rdReq,
  input  logic              rdAck,
  input  logic [W-1:0]      rdData,
  output logic              wrReq,
  input  logic              wrAck,
  output logic [W-1:0]      wrData,
  input  logic [W-1:0]      dipType,
  input  logic [W-1:0]      dipNum,
  output logic              buzzReq,
  output logic              drawStart,
  output logic [DRAW_W-1:0] drawValue,
  input  logic              drawDone,
  output logic              busy
);

  dpCtrl_t ctrl;
  logic    typeMatch, numMatch;

  session_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostReady (hostReady),
    .rdAck     (rdAck),
    .wrAck     (wrAck),
    .drawDone  (drawDone),
    .typeMatch (typeMatch),
    .numMatch  (numMatch),
    .ctrl      (ctrl),
    .rdReq     (rdReq),
    .wrReq     (wrReq),
    .buzzReq   (buzzReq),
    .drawStart (drawStart),
    .busy      (busy)
  );

  session_seq_dp #(.W(W), .DRAW_W(DRAW_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .rdData     (rdData),
    .dipType    (dipType),
    .dipNum     (dipNum),
    .typeMatch  (typeMatch),
    .numMatch   (numMatch),
    .resultCode (wrData),
    .drawValue  (drawValue)
  );

endmodule

// File: rtl/session_seq_chk.sv
module session_seq_chk
  import session_seq_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         rdReq,
  input logic         rdAck,
  input logic         wrReq,
  input logic         wrAck,
  input logic [W-1:0] wrData,
  input logic         buzzReq,
  input logic         drawStart,
  input logic         busy
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!rdReq && !wrReq && !buzzReq && !drawStart));

  a_r2_read_held: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck) |=> rdReq);

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(rdReq && wrReq));

  a_r4_buzz_pulse: assert property (@(posedge clk) disable iff (!rstN)
    buzzReq |=> !buzzReq);

  a_r8_draw_pulse: assert property (@(posedge clk) disable iff (!rstN)
    drawStart |=> !drawStart);

  a_r8_draw_on_success: assert property (@(posedge clk) disable iff (!rstN)
    drawStart |-> (wrData == W'(CODE_OK)));

  a_r10_write_held: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !wrAck) |=> (wrReq && $stable(wrData)));

  a_r10_busy_ends_on_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(wrReq && wrAck));

endmodule

bind session_seq session_seq_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rdReq     (rdReq),
  .rdAck     (rdAck),
  .wrReq     (wrReq),
  .wrAck     (wrAck),
  .wrData    (wrData),
  .buzzReq   (buzzReq),
  .drawStart (drawStart),
  .busy      (busy)
);

// File: tb/session_seq_tb.sv
`timescale 1ns/1ps
module session_seq_tb;

  localparam int W = 8;
  localparam int DRAW_W = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostReady = 1'b0;
  logic rdAck = 1'b0;
  logic [W-1:0] rdData = '0;
  logic wrAck = 1'b0;
  logic [W-1:0] dipType = '0;
  logic [W-1:0] dipNum = '0;
  logic drawDone = 1'b0;
  logic rdReq, wrReq, buzzReq, drawStart, busy;
  logic [W-1:0] wrData;
  logic [DRAW_W-1:0] drawValue;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  session_seq #(.W(W), .DRAW_W(DRAW_W)) u_dut (
    .clk(clk), .rstN(rstN), .hostReady(hostReady),
    .rdReq(rdReq), .rdAck(rdAck), .rdData(rdData),
    .wrReq(wrReq), .wrAck(wrAck), .wrData(wrData),
    .dipType(dipType), .dipNum(dipNum),
    .buzzReq(buzzReq), .drawStart(drawStart), .drawValue(drawValue),
    .drawDone(drawDone), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R1: quiet after reset and while hostReady stays low
  task automatic testResetIdle();
    bit loud = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !rdReq && !wrReq && !buzzReq && !drawStart, "R1",
          "outputs after reset", int'({busy, rdReq, wrReq, buzzReq, drawStart}), 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (busy || rdReq || wrReq) loud = 1'b1;
    end
    check(!loud, "R1", "activity without hostReady", int'(loud), 0);
  endtask

  task automatic runSession(input logic [W-1:0] tType, input logic [W-1:0] tNum,
                            input logic [W-1:0] tDraw, input logic [W-1:0] dT,
                            input logic [W-1:0] dN, input int stall,
                            input int drawDelay, input bit swapDip, input string tag);
    logic [W-1:0] bytes [3];
    int expCode, idx, buzzCnt, drawCnt, stallCnt, dWait, wrVal;
    bit buzzBad, earlyWr, wrSeen, busyGap;
    logic [DRAW_W-1:0] drawVal;
    bytes[0] = tType; bytes[1] = tNum; bytes[2] = tDraw;
    expCode = (dT != tType) ? 1 : ((dN != tNum) ? 2 : 5);
    idx = 0; buzzCnt = 0; drawCnt = 0; stallCnt = stall; dWait = 0; wrVal = -1;
    buzzBad = 0; earlyWr = 0; wrSeen = 0; busyGap = 0; drawVal = '0;
    dipType = dT; dipNum = dN; drawDone = 1'b0;

    @(negedge clk) hostReady = 1'b1;
    @(negedge clk) hostReady = 1'b0;
    check(busy == 1'b1, "R10", {tag, " busy after start"}, int'(busy), 1);

    for (int cyc = 0; cyc < 400 && !wrSeen; cyc++) begin
      rdAck = 1'b0;
      wrAck = 1'b0;
      if (!busy) busyGap = 1'b1;
      if (wrReq) begin
        if (expCode == 5 && !drawDone) earlyWr = 1'b1;
        if (stallCnt > 0) stallCnt--;
        else begin
          wrAck = 1'b1;
          wrVal = int'(wrData);
          wrSeen = 1'b1;
        end
      end
      if (buzzReq) begin
        buzzCnt++;
        if (idx != 3 || drawCnt != 0) buzzBad = 1'b1;
      end
      if (drawStart) begin
        drawCnt++;
        drawVal = drawValue;
        dWait = drawDelay;
      end else if (drawCnt > 0 && !drawDone) begin
        if (dWait <= 1) drawDone = 1'b1;
        else dWait--;
      end
      if (rdReq) begin
        if (stallCnt > 0) stallCnt--;
        else begin
          rdAck = 1'b1;
          rdData = bytes[idx];
          idx++;
          stallCnt = stall;
          if (swapDip && idx == 1) begin
            dipType = ~dT;
            dipNum = ~dN;
          end
        end
      end
      @(negedge clk);
    end
    rdAck = 1'b0;
    wrAck = 1'b0;

    check(wrSeen, "R10", {tag, " result written"}, int'(wrSeen), 1);
    check(wrVal == expCode, (expCode == 1) ? "R5" : ((expCode == 2) ? "R6" : "R7"),
          {tag, swapDip ? " code with switches changed (R3)" : " result code"},
          wrVal, expCode);
    check(idx == 3, "R2", {tag, " bytes read"}, idx, 3);
    check(buzzCnt == 1 && !buzzBad, "R4", {tag, " buzzer pulses"}, buzzCnt, 1);
    if (expCode == 5) begin
      check(drawCnt == 1, "R8", {tag, " draw starts"}, drawCnt, 1);
      check(drawVal == tDraw[DRAW_W-1:0], "R8", {tag, " draw value"},
            int'(drawVal), int'(tDraw[DRAW_W-1:0]));
      check(!earlyWr, "R9", {tag, " write before drawDone"}, int'(earlyWr), 0);
    end else begin
      check(drawCnt == 0, "R8", {tag, " draw starts on error"}, drawCnt, 0);
    end
    check(!busyGap, "R10", {tag, " busy held during session"}, int'(busyGap), 0);
    check(busy == 1'b0, "R10", {tag, " busy after write"}, int'(busy), 0);
    drawDone = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    testResetIdle();
    runSession(8'h3C, 8'h17, 8'h02, 8'h3C, 8'h17, 0, 3, 1'b0, "match");
    runSession(8'h3C, 8'h17, 8'h01, 8'h3D, 8'h17, 0, 1, 1'b0, "type mismatch");
    runSession(8'h3C, 8'h17, 8'h01, 8'h3C, 8'h18, 0, 1, 1'b0, "number mismatch");
    runSession(8'h3C, 8'h17, 8'h03, 8'h40, 8'h99, 0, 1, 1'b0, "both mismatch");
    runSession(8'hA5, 8'h5A, 8'hFF, 8'hA5, 8'h5A, 3, 6, 1'b0, "stalled match");
    runSession(8'h11, 8'h22, 8'h0E, 8'h11, 8'h22, 0, 2, 1'b1, "dip swap");
    runSession(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 2, 9, 1'b0, "zero ids");
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule